// File: doc/BRIEF.md
# Modulo 2^K+1 Inverted-Carry Prefix Adder

This block adds two K-bit operands and returns the K-bit result of a modulo 2^K+1 addition in the diminished-by-one style. When the binary sum of the operands overflows K bits, the low K bits are passed through unchanged. When it does not overflow, the low K bits are taken after adding one. A squarer or multiplier for that modulus uses it as its final carry-propagate stage, fed by the sum and carry vectors of its reduction tree.

The carries come from a cyclic parallel-prefix network with log2 K levels. Each level folds the inverted carry from the top of the word back into the low positions. No carry-out wire loops back to a carry input, and there is no trailing increment stage. A second output reports whether every bit position propagates, which is true exactly when the operands are bitwise complements. The block is purely combinational.

Top module: `invcarry_prefix_adder`

## Requirements
- R1: When opnd_a + opnd_b (taken as unsigned integers) is at least 2^K, sum_o equals the low K bits of opnd_a + opnd_b.
- R2: When opnd_a + opnd_b is below 2^K, sum_o equals (opnd_a + opnd_b + 1) mod 2^K. For example, two zero operands give sum_o = 1.
- R3: When opnd_b is the bitwise complement of opnd_a, so that the sum is 2^K-1, sum_o is all zeros.
- R4: allprop_o is 1 exactly when opnd_a XOR opnd_b is all ones, and 0 otherwise.
- R5: Exchanging opnd_a and opnd_b leaves both sum_o and allprop_o unchanged.
- R6: The outputs depend only on the present operands. The same operand pair yields the same outputs whatever pairs were applied before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | K | First operand, unsigned |
| opnd_b | input | K | Second operand, unsigned |
| sum_o | output | K | K-bit modulo result with inverted end-around carry |
| allprop_o | output | 1 | High when every bit position propagates |

## Verification
The bench builds two copies of the block, one with K = 8 and one with K = 4. Both are swept over every operand pair (65,536 and 256 pairs). This covers both sides of the overflow boundary, every complementary pair in which all positions propagate, and every wrap-around path through the prefix levels at two network depths. Results from the 4-bit copy are stored and then compared against swapped operands and against pairs applied again after unrelated stimulus.

// File: rtl/invcarry_pkg.sv
package invcarry_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } gp_pair_t;

  // Ordinary prefix combine: hi covers more significant bits than lo.
  function automatic gp_pair_t gp_merge(input gp_pair_t hi, input gp_pair_t lo);
    gp_pair_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // Wrapped combine: the lower group sits above the word top, so its
  // carry re-enters inverted. The inverted carry of a group is its kill term.
  function automatic gp_pair_t gp_merge_wrap(input gp_pair_t hi, input gp_pair_t lo);
    gp_pair_t r;
    r.g = hi.g | (hi.p & ~lo.g & ~lo.p);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/invcarry_bitgp.sv
module invcarry_bitgp #(
  parameter int K = 8
) (
  input  logic [K-1:0] x_i,
  input  logic [K-1:0] y_i,
  output logic [K-1:0] gen_o,
  output logic [K-1:0] prop_o
);
  for (genvar i = 0; i < K; i++) begin : g_bit
    assign gen_o[i]  = x_i[i] & y_i[i];
    assign prop_o[i] = x_i[i] ^ y_i[i];
  end
endmodule

// File: rtl/invcarry_prefix_level.sv
module invcarry_prefix_level
  import invcarry_pkg::*;
#(
  parameter int K    = 8,
  parameter int DIST = 1
) (
  input  logic [K-1:0] gen_i,
  input  logic [K-1:0] prop_i,
  output logic [K-1:0] gen_o,
  output logic [K-1:0] prop_o
);
  for (genvar i = 0; i < K; i++) begin : g_node
    gp_pair_t own, nbr, res;
    assign own.g = gen_i[i];
    assign own.p = prop_i[i];
    if (i >= DIST) begin : g_plain
      assign nbr.g = gen_i[i-DIST];
      assign nbr.p = prop_i[i-DIST];
      assign res   = gp_merge(own, nbr);
    end else begin : g_wrap
      assign nbr.g = gen_i[i-DIST+K];
      assign nbr.p = prop_i[i-DIST+K];
      assign res   = gp_merge_wrap(own, nbr);
    end
    assign gen_o[i]  = res.g;
    assign prop_o[i] = res.p;
  end
endmodule

// File: rtl/invcarry_sum_stage.sv
module invcarry_sum_stage #(
  parameter int K = 8
) (
  input  logic [K-1:0] bitprop_i,
  input  logic [K-1:0] grpgen_i,
  input  logic         allprop_i,
  output logic [K-1:0] sum_o
);
  logic [K-1:0] carry_in;

  // Bit 0 receives the inverted group generate of the full word. When all
  // positions propagate, every carry is forced so the result wraps to zero.
  assign carry_in[0] = ~grpgen_i[K-1] | allprop_i;
  for (genvar i = 1; i < K; i++) begin : g_cin
    assign carry_in[i] = grpgen_i[i-1] | allprop_i;
  end

  assign sum_o = bitprop_i ^ carry_in;
endmodule

// File: rtl/invcarry_prefix_adder.sv
module invcarry_prefix_adder #(
  parameter int K = 8
) (
  input  logic [K-1:0] opnd_a,
  input  logic [K-1:0] opnd_b,
  output logic [K-1:0] sum_o,
  output logic         allprop_o
);
  localparam int LEVELS = $clog2(K);

  logic [K-1:0]            bit_g, bit_p;
  logic [LEVELS:0][K-1:0]  lvl_g, lvl_p;

  invcarry_bitgp #(.K(K)) u_bitgp (
    .x_i    (opnd_a),
    .y_i    (opnd_b),
    .gen_o  (bit_g),
    .prop_o (bit_p)
  );

  assign lvl_g[0] = bit_g;
  assign lvl_p[0] = bit_p;

  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    invcarry_prefix_level #(.K(K), .DIST(1 << l)) u_lvl (
      .gen_i  (lvl_g[l]),
      .prop_i (lvl_p[l]),
      .gen_o  (lvl_g[l+1]),
      .prop_o (lvl_p[l+1])
    );
  end

  assign allprop_o = lvl_p[LEVELS][K-1];

  invcarry_sum_stage #(.K(K)) u_sum (
    .bitprop_i (bit_p),
    .grpgen_i  (lvl_g[LEVELS]),
    .allprop_i (allprop_o),
    .sum_o     (sum_o)
  );
endmodule

// File: rtl/invcarry_prefix_adder_chk.sv
module invcarry_prefix_adder_chk #(
  parameter int K = 8
) (
  input logic [K-1:0] opnd_a,
  input logic [K-1:0] opnd_b,
  input logic [K-1:0] sum_o,
  input logic         allprop_o
);
  logic [K:0] wide;
  assign wide = {1'b0, opnd_a} + {1'b0, opnd_b};

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, sum_o, allprop_o})) begin
      // R1: overflowing sum passes its low bits unchanged
      if (wide[K]) a_r1_overflow_pass: assert (sum_o == wide[K-1:0]);
      // R2: non-overflowing sum is incremented
      if (!wide[K]) a_r2_increment: assert (sum_o == wide[K-1:0] + 1'b1);
      // R3: complementary operands give zero
      if (opnd_b == ~opnd_a) a_r3_compl_zero: assert (sum_o == '0);
      // R4: all-propagate flag matches operand complementarity
      a_r4_allprop: assert (allprop_o == (opnd_b == ~opnd_a));
    end
  end
endmodule

bind invcarry_prefix_adder invcarry_prefix_adder_chk #(.K(K)) u_chk (
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .sum_o     (sum_o),
  .allprop_o (allprop_o)
);

// File: tb/invcarry_prefix_adder_test.sv
`timescale 1ns/1ps
module invcarry_prefix_adder_test;
  localparam time CLK_HALF = 10ns;

  logic clk = 1'b0;
  always #(CLK_HALF) clk = ~clk;

  logic [7:0] a8 = '0, b8 = '0, s8;
  logic [3:0] a4 = '0, b4 = '0, s4;
  logic       p8, p4;

  int checks = 0;
  int errors = 0;
  logic [4:0] res4 [256];

  invcarry_prefix_adder #(.K(8)) uut (
    .opnd_a(a8), .opnd_b(b8), .sum_o(s8), .allprop_o(p8));
  invcarry_prefix_adder #(.K(4)) uut_k4 (
    .opnd_a(a4), .opnd_b(b4), .sum_o(s4), .allprop_o(p4));

  task automatic check(input string req, input int act, input int exp, input int x, input int y);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, x, y, act, exp);
    end
  endtask

  function automatic int mod_sum(input int x, input int y, input int k);
    int s = x + y;
    int m = 1 << k;
    return (s >= m) ? s - m : (s + 1) % m;
  endfunction

  task automatic check_pair(input int k, input int x, input int y, input int act_s, input int act_p);
    int m = 1 << k;
    int s = x + y;
    if (s >= m) check("R1", act_s, mod_sum(x, y, k), x, y);
    else        check("R2", act_s, mod_sum(x, y, k), x, y);
    if (s == m - 1) check("R3", act_s, 0, x, y);
    check("R4", act_p, (s == m - 1 && (x ^ y) == m - 1) ? 1 : 0, x, y);
  endtask

  initial begin
    #(CLK_HALF * 2 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // Initial state with zero operands: R2 gives 1
    @(negedge clk);
    check("R2", int'(s8), 1, 0, 0);
    check("R2", int'(s4), 1, 0, 0);

    for (int i = 0; i < 65536; i++) begin
      @(posedge clk);
      a8 = i[15:8];
      b8 = i[7:0];
      if (i < 256) begin
        a4 = i[7:4];
        b4 = i[3:0];
      end
      @(negedge clk);
      check_pair(8, int'(a8), int'(b8), int'(s8), int'(p8));
      if (i < 256) begin
        check_pair(4, int'(a4), int'(b4), int'(s4), int'(p4));
        res4[i] = {p4, s4};
      end
    end

    // R5: swapped operands reproduce the stored outputs
    for (int i = 0; i < 256; i++) begin
      @(posedge clk);
      a4 = i[3:0];
      b4 = i[7:4];
      @(negedge clk);
      check("R5", int'({p4, s4}), int'(res4[i]), i[3:0], i[7:4]);
    end

    // R6: re-applied pairs after unrelated stimulus give identical outputs
    for (int i = 255; i >= 0; i -= 17) begin
      @(posedge clk);
      a4 = 4'hF; b4 = 4'h0;
      @(posedge clk);
      a4 = i[7:4]; b4 = i[3:0];
      @(negedge clk);
      check("R6", int'({p4, s4}), int'(res4[i]), i[7:4], i[3:0]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule